// File: doc/BRIEF.md
# Stall-Hiding Thread Issue Scheduler

This block decides, clock by clock, which thread context of a SIMD shader core issues its next vector instruction. Only one thread issues in any cycle. The chosen thread keeps issuing back to back until it sends out a texture fetch. The core then hands the issue slot at once to another thread that can run. The stalled context waits out a fixed texture latency and then becomes selectable again. Threads are picked in round-robin order, starting just after the thread that gave up the slot.

A launch pulse starts a shader and carries that shader's per-thread register need. The shared vector register pool is split into equal slices of that size. This fixes how many contexts take part, up to the context limit, and where each context's registers start in the pool. The instruction source outside the block shows two flags for the next instruction of every thread: whether it is a texture access, and whether it ends that thread's stream. Cycles in which no context can issue are counted on an idle counter.

Top module: `mt_issue_sched`

## Requirements
- R1: On a launch, the number of active contexts becomes min(floor(POOL_REGS / reg_need), NUM_CTX). With the defaults this is min(16 / reg_need, 4). It is zero when reg_need is 0 or larger than the pool. Contexts 0 up to that count minus one are active, and `ctx_count` reports the count.
- R2: Field i of `reg_base` occupies bits [4*i+3 : 4*i]. It holds i × reg_need for an active context and 0 for an inactive one.
- R3: In the first cycle after the launch edge, context 0 issues if at least one context is active. At most one thread issues per cycle. `issue_tid` always names an active context while `issue_vld` is high.
- R4: A thread that issues an instruction flagged neither texture nor last also issues in the following cycle.
- R5: When the issuing thread sends a texture instruction or its last instruction, the next cycle issues from the first eligible context in the circular order issue_tid+1, issue_tid+2, and so on. If no context is eligible, nothing issues.
- R6: A thread whose texture instruction issued in cycle c can issue again no earlier than cycle c + TEX_LAT (50). If the core is idle, or the running thread stalls, by cycle c + TEX_LAT − 1, the thread issues in exactly cycle c + TEX_LAT.
- R7: In every cycle with no issue while at least one active context is unfinished, `idle_cnt` increases by one. A launch clears it.
- R8: A thread that issues its last instruction is finished and never issues again; the last flag wins over the texture flag. `all_done` is high once every active context is finished.
- R9: After reset, `issue_vld` is 0, `idle_cnt` is 0, `ctx_count` is 0 and `all_done` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| launch | input | 1 | One-cycle pulse that starts a shader |
| reg_need | input | 5 | Registers needed per thread, sampled at launch |
| nxt_tex | input | 4 | Per thread: the next instruction is a texture access |
| nxt_last | input | 4 | Per thread: the next instruction ends the stream |
| issue_vld | output | 1 | An instruction issues this cycle |
| issue_tid | output | 2 | Context that issues this cycle |
| ctx_count | output | 3 | Number of active contexts |
| reg_base | output | 16 | Pool base register of each context, 4 bits each |
| idle_cnt | output | 16 | Count of cycles with no issue |
| all_done | output | 1 | Every active context has finished |

## Verification
The bench drives nine shader launches whose streams are built from an arithmetic run length per thread and a segment count. The uniform 20-instruction runs with four contexts check that stalls are hidden completely, with zero idle cycles. The same stream with two contexts and with one context checks the exact idle totals of 28 and 49 cycles. Streams where every instruction is a texture access, and streams with a different run length per thread, make several contexts become ready close together, which tells round-robin order apart from lowest-index order. Register needs of 0, 1, 2, 3, 5, 8, 16 and 17 cover the rounding of the pool split, the cap at four contexts and the case of no context at all. Each cycle's issue is compared with a cycle-level model that computes readiness in the bench.

// File: rtl/mt_sched_pkg.sv
package mt_sched_pkg;
   typedef enum logic [1:0] {
      CTX_OFF   = 2'd0,
      CTX_READY = 2'd1,
      CTX_WAIT  = 2'd2,
      CTX_DONE  = 2'd3
   } ctx_state_e;
endpackage

// File: rtl/mt_reg_part.sv
// Splits the register pool into equal per-context slices.
module mt_reg_part #(
   parameter int NUM_CTX   = 4,
   parameter int POOL_REGS = 16,
   parameter int NW        = 5,
   parameter int BW        = 4,
   parameter int CW        = 3
) (
   input  logic [NW-1:0]         need,
   output logic [NUM_CTX-1:0]    fits,
   output logic [CW-1:0]         count,
   output logic [NUM_CTX*BW-1:0] base
);
   localparam int PW = NW + $clog2(NUM_CTX) + 1;

   for (genvar i = 0; i < NUM_CTX; i++) begin : g_ctx
      logic [PW-1:0] lo;
      logic [PW-1:0] hi;
      assign lo      = PW'(i) * PW'(need);
      assign hi      = lo + PW'(need);
      assign fits[i] = (need != '0) && (hi <= PW'(POOL_REGS));
      assign base[i*BW +: BW] = fits[i] ? lo[BW-1:0] : '0;
   end

   always_comb begin
      count = '0;
      for (int i = 0; i < NUM_CTX; i++) count = count + CW'(fits[i]);
   end

   always_comb begin
      for (int i = 1; i < NUM_CTX; i++) begin
         AST_FITS_ORDERED: assert (!fits[i] || fits[i-1]); // R1
      end
   end
endmodule

// File: rtl/mt_rr_pick.sv
// Circular first-hit search starting at a given index.
module mt_rr_pick #(
   parameter int NUM_CTX = 4,
   parameter int TW      = 2
) (
   input  logic [NUM_CTX-1:0] req,
   input  logic [TW-1:0]      start,
   output logic               found,
   output logic [TW-1:0]      idx
);
   int j;

   always_comb begin
      found = 1'b0;
      idx   = start;
      j     = 0;
      for (int k = 0; k < NUM_CTX; k++) begin
         j = int'(start) + k;
         if (j >= NUM_CTX) j = j - NUM_CTX;
         if (!found && req[j]) begin
            found = 1'b1;
            idx   = TW'(j);
         end
      end
   end

   always_comb begin
      if (found) begin
         AST_PICK_HAS_REQ: assert (req[idx]); // R5
      end
   end
endmodule

// File: rtl/mt_ctx_slot.sv
// State and texture countdown of one thread context.
module mt_ctx_slot
   import mt_sched_pkg::*;
#(
   parameter int TEX_LAT = 50,
   parameter int LW      = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic launch,
   input  logic enable,
   input  logic issue_here,
   input  logic is_tex,
   input  logic is_last,
   output logic elig,
   output logic fin
);
   ctx_state_e    st;
   logic [LW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= CTX_OFF;
         cnt <= '0;
      end else if (launch) begin
         st  <= enable ? CTX_READY : CTX_OFF;
         cnt <= '0;
      end else begin
         unique case (st)
            CTX_READY: begin
               if (issue_here) begin
                  if (is_last) begin
                     st <= CTX_DONE;
                  end else if (is_tex) begin
                     st  <= CTX_WAIT;
                     cnt <= LW'(TEX_LAT - 2);
                  end
               end
            end
            CTX_WAIT: begin
               if (cnt == '0) st <= CTX_READY;
               else           cnt <= cnt - 1'b1;
            end
            default: ;
         endcase
      end
   end

   // a zero countdown is already eligible, so the wake-up costs no cycle
   assign elig = ((st == CTX_READY) && !issue_here) || ((st == CTX_WAIT) && (cnt == '0));
   assign fin  = (st == CTX_OFF) || (st == CTX_DONE);

   AST_NO_EARLY_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
      (st == CTX_WAIT && cnt != '0) |-> !issue_here); // R6
   AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (st == CTX_DONE && !launch) |=> (st == CTX_DONE)); // R8
   AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (st == CTX_OFF) |-> !issue_here); // R1
endmodule

// File: rtl/mt_issue_sched.sv
module mt_issue_sched
   import mt_sched_pkg::*;
#(
   parameter int NUM_CTX   = 4,
   parameter int POOL_REGS = 16,
   parameter int TEX_LAT   = 50,
   parameter int IDLE_W    = 16,
   localparam int NW = $clog2(POOL_REGS) + 1,
   localparam int BW = $clog2(POOL_REGS),
   localparam int CW = $clog2(NUM_CTX + 1),
   localparam int TW = $clog2(NUM_CTX),
   localparam int LW = $clog2(TEX_LAT)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  launch,
   input  logic [NW-1:0]         reg_need,
   input  logic [NUM_CTX-1:0]    nxt_tex,
   input  logic [NUM_CTX-1:0]    nxt_last,
   output logic                  issue_vld,
   output logic [TW-1:0]         issue_tid,
   output logic [CW-1:0]         ctx_count,
   output logic [NUM_CTX*BW-1:0] reg_base,
   output logic [IDLE_W-1:0]     idle_cnt,
   output logic                  all_done
);
   if (NUM_CTX < 2)   begin : g_bad_ctx  $error("NUM_CTX must be at least 2");   end
   if (TEX_LAT < 2)   begin : g_bad_lat  $error("TEX_LAT must be at least 2");   end
   if (POOL_REGS < 2) begin : g_bad_pool $error("POOL_REGS must be at least 2"); end

   logic [NW-1:0]      need_q;
   logic [NW-1:0]      need_sel;
   logic [NUM_CTX-1:0] fits;
   logic [NUM_CTX-1:0] elig;
   logic [NUM_CTX-1:0] fin;
   logic [NUM_CTX-1:0] issue_here;
   logic [TW-1:0]      rr_start;
   logic [TW-1:0]      pick;
   logic               found;
   logic               stop;

   assign need_sel = launch ? reg_need : need_q;

   mt_reg_part #(
      .NUM_CTX(NUM_CTX), .POOL_REGS(POOL_REGS), .NW(NW), .BW(BW), .CW(CW)
   ) u_part (
      .need(need_sel), .fits(fits), .count(ctx_count), .base(reg_base)
   );

   for (genvar i = 0; i < NUM_CTX; i++) begin : g_slot
      assign issue_here[i] = issue_vld && (issue_tid == TW'(i));
      mt_ctx_slot #(.TEX_LAT(TEX_LAT), .LW(LW)) u_slot (
         .clk(clk), .rst_n(rst_n), .launch(launch), .enable(fits[i]),
         .issue_here(issue_here[i]), .is_tex(nxt_tex[i]), .is_last(nxt_last[i]),
         .elig(elig[i]), .fin(fin[i])
      );
   end

   assign rr_start = (issue_tid == TW'(NUM_CTX - 1)) ? '0 : issue_tid + 1'b1;

   mt_rr_pick #(.NUM_CTX(NUM_CTX), .TW(TW)) u_pick (
      .req(elig), .start(rr_start), .found(found), .idx(pick)
   );

   assign stop     = issue_vld && (nxt_tex[issue_tid] || nxt_last[issue_tid]);
   assign all_done = &fin;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         issue_vld <= 1'b0;
         issue_tid <= '0;
         need_q    <= '0;
         idle_cnt  <= '0;
      end else if (launch) begin
         need_q    <= reg_need;
         issue_vld <= fits[0];
         issue_tid <= '0;
         idle_cnt  <= '0;
      end else begin
         if (!issue_vld || stop) begin
            issue_vld <= found;
            if (found) issue_tid <= pick;
         end
         if (!issue_vld && !all_done) idle_cnt <= idle_cnt + 1'b1;
      end
   end

   AST_TID_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_vld && !launch) |-> (CW'(issue_tid) < ctx_count)); // R3
   AST_STAY_ON_ARITH: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_vld && !nxt_tex[issue_tid] && !nxt_last[issue_tid] && !launch)
      |=> (issue_vld && $stable(issue_tid))); // R4
   AST_SWITCH_ON_TEX: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_vld && nxt_tex[issue_tid] && !launch)
      |=> (!issue_vld || (issue_tid != $past(issue_tid)))); // R5
   AST_IDLE_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (!issue_vld && !all_done && !launch)
      |=> (idle_cnt == IDLE_W'($past(idle_cnt) + 1'b1))); // R7
   AST_SILENT_WHEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (all_done && !launch) |=> !issue_vld); // R8
endmodule

// File: tb/mt_issue_sched_bench.sv
module mt_issue_sched_bench;
   localparam int N    = 4;
   localparam int POOL = 16;
   localparam int LAT  = 50;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        launch;
   logic [4:0]  reg_need;
   logic [3:0]  nxt_tex;
   logic [3:0]  nxt_last;
   logic        issue_vld;
   logic [1:0]  issue_tid;
   logic [2:0]  ctx_count;
   logic [15:0] reg_base;
   logic [15:0] idle_cnt;
   logic        all_done;

   int pc[N];
   int kseg[N];
   int nseg;
   int compared   = 0;
   int mismatched = 0;

   always #10 clk = ~clk;

   mt_issue_sched u_mt_issue_sched (
      .clk(clk), .rst_n(rst_n), .launch(launch), .reg_need(reg_need),
      .nxt_tex(nxt_tex), .nxt_last(nxt_last), .issue_vld(issue_vld),
      .issue_tid(issue_tid), .ctx_count(ctx_count), .reg_base(reg_base),
      .idle_cnt(idle_cnt), .all_done(all_done)
   );

   // instruction streams: runs of kseg arithmetic ops, each closed by a texture op
   always_comb begin
      for (int t = 0; t < N; t++) begin
         nxt_tex[t]  = ((pc[t] % (kseg[t] + 1)) == kseg[t]);
         nxt_last[t] = (pc[t] == nseg * (kseg[t] + 1) - 1);
      end
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      compared++;
      if (!ok) begin
         mismatched++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic run_case(input int need, input int k0, input int k1, input int k2,
                           input int k3, input int segs, input int exp_idle);
      int  act_n, m_cur, pend, eidle, len[N], ready_at[N];
      bit  m_run, mdone[N], stp, alld;
      kseg[0] = k0; kseg[1] = k1; kseg[2] = k2; kseg[3] = k3;
      nseg = segs;
      for (int t = 0; t < N; t++) pc[t] = 0;
      act_n = (need == 0) ? 0 : (((POOL / need) > N) ? N : POOL / need);
      @(negedge clk);
      launch   = 1'b1;
      reg_need = need[4:0];
      @(negedge clk);
      launch = 1'b0;
      check(ctx_count == act_n[2:0], $sformatf("R1 ctx_count need=%0d", need), ctx_count, act_n);
      for (int i = 0; i < N; i++) begin
         int eb = (i < act_n) ? i * need : 0;
         check(reg_base[i*4 +: 4] == eb[3:0], $sformatf("R2 reg_base[%0d] need=%0d", i, need),
               reg_base[i*4 +: 4], eb);
      end
      for (int t = 0; t < N; t++) begin
         len[t] = segs * (kseg[t] + 1);
         ready_at[t] = 0;
         mdone[t] = (t >= act_n);
      end
      m_run = (act_n > 0);
      m_cur = 0;
      pend  = -1;
      eidle = 0;
      for (int k = 0; k < 3000; k++) begin
         if (pend >= 0) pc[pend]++;
         check(issue_vld == m_run && (!m_run || issue_tid == m_cur[1:0]),
               $sformatf("R5 issue cycle %0d need=%0d", k, need),
               issue_vld ? int'(issue_tid) : -1, m_run ? m_cur : -1);
         stp = 1'b0;
         if (m_run) begin
            pend = m_cur;
            if (pc[m_cur] == len[m_cur] - 1) begin
               mdone[m_cur] = 1'b1;
               stp = 1'b1;
            end else if ((pc[m_cur] % (kseg[m_cur] + 1)) == kseg[m_cur]) begin
               ready_at[m_cur] = k + LAT;
               stp = 1'b1;
            end
         end else begin
            pend = -1;
         end
         alld = 1'b1;
         for (int t = 0; t < N; t++) if (!mdone[t]) alld = 1'b0;
         if (!m_run && !alld) eidle++;
         if (!m_run || stp) begin
            int base = m_cur;
            m_run = 1'b0;
            for (int o = 1; o <= N; o++) begin
               int j = (base + o) % N;
               if (!m_run && !mdone[j] && ready_at[j] <= k + 1) begin
                  m_run = 1'b1;
                  m_cur = j;
               end
            end
         end
         @(negedge clk);
         if (alld) break;
      end
      if (pend >= 0) pc[pend]++;
      check(issue_vld == 1'b0, $sformatf("R8 silent after finish need=%0d", need), issue_vld, 0);
      check(all_done == 1'b1, $sformatf("R8 all_done need=%0d", need), all_done, 1);
      check(idle_cnt == eidle[15:0], $sformatf("R7 idle model need=%0d", need), idle_cnt, eidle);
      if (exp_idle >= 0)
         check(idle_cnt == exp_idle[15:0], $sformatf("R7 idle total need=%0d", need), idle_cnt, exp_idle);
      repeat (4) @(negedge clk);
      check(issue_vld == 1'b0 && idle_cnt == eidle[15:0],
            $sformatf("R8 no issue after done need=%0d", need), idle_cnt, eidle);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      mismatched++;
      $display("FAIL R3 watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      rst_n    = 1'b0;
      launch   = 1'b0;
      reg_need = '0;
      nseg     = 1;
      for (int t = 0; t < N; t++) begin
         pc[t]   = 0;
         kseg[t] = 0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(issue_vld == 1'b0, "R9 reset issue_vld", issue_vld, 0);
      check(idle_cnt == 16'd0, "R9 reset idle_cnt", idle_cnt, 0);
      check(ctx_count == 3'd0, "R9 reset ctx_count", ctx_count, 0);
      check(all_done == 1'b1, "R9 reset all_done", all_done, 1);
      // four contexts hide a 50-cycle fetch behind 21-cycle runs: R4 R6
      run_case(4, 20, 20, 20, 20, 2, 0);
      // two contexts: idle from cycle 42 to 69
      run_case(8, 20, 20, 20, 20, 2, 28);
      // one context: idle from cycle 6 to 54
      run_case(16, 5, 5, 5, 5, 2, 49);
      run_case(5, 3, 7, 1, 4, 3, -1);
      run_case(1, 0, 0, 0, 0, 5, -1);
      run_case(2, 10, 2, 2, 2, 3, -1);
      run_case(3, 0, 1, 2, 3, 4, -1);
      run_case(17, 2, 2, 2, 2, 1, 0);
      run_case(0, 2, 2, 2, 2, 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule